// File: doc/BRIEF.md
# Free-Running Timer with Dual Compare

This block is a 16-bit up-counter that advances on a one-cycle timer tick. Two compare registers are checked on every tick, and a wrap detector watches the counter. Each event sets a sticky flag in a status register. An enabled event raises an interrupt request that carries a fixed vector number. The first compare register can, under a control bit, reset the counter to zero. This makes the counter a periodic timebase with a programmable period.

Software reaches the block through a small word-wide register port: the counter, compare A, compare B, status/control and interrupt enable. The request is presented as a valid signal with a vector. It stays in place until a separate sequencer acknowledges it.

Top module: `frt_dual_cmp`

## Requirements
- R1: With `tick` low and no software write to the counter, the counter holds. Each cycle with `tick` high and no counter write adds one to it, modulo 2^16.
- R2: Compares use the counter value from before the tick's increment. A tick in which that value equals compare A sets status bit 0 (compare-A flag).
- R3: When status bit 3 (clear-on-A) is 1 and a tick sees a compare-A match, the counter becomes 0 in place of the increment. That tick sets no overflow flag, even when the old value was 0xFFFF.
- R4: A tick in which the old counter value equals compare B sets status bit 1 (compare-B flag). A compare-B match never clears the counter.
- R5: A tick that wraps the counter from 0xFFFF to 0x0000 sets status bit 2 (overflow flag).
- R6: An event raises a request only if its enable bit is 1. The enable bits are bit 0 for compare A (vector 16), bit 1 for compare B (vector 17) and bit 2 for overflow (vector 18). Flags are set whether enabled or not.
- R7: When several enabled events occur in one tick, the vector is 18 over 17 over 16.
- R8: Flags are sticky. Writing 0 to a flag bit clears it, and writing 1 leaves it unchanged. An event in the same cycle as a clearing write leaves the flag set.
- R9: `irq_valid` and `irq_vector` change one cycle after the event. They hold unchanged until `irq_ack`, and events while a request is held only set flags. A cycle with `irq_ack` either drops the request or, if a new enabled event occurs in that cycle, loads the new one.
- R10: A software write to the counter takes effect in place of a tick in the same cycle. That tick performs no compare and no overflow check.
- R11: After reset the counter is 0. Both compare registers are 0xFFFF. Status and enable are 0, and no request is valid.
- R12: The read address selects the register as follows: 0 counter, 1 compare A, 2 compare B, 3 status/control, 4 enable. Other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Timer advance strobe |
| bus_addr | input | 3 | Register select for read and write |
| bus_we | input | 1 | Write strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq_ack | input | 1 | Sequencer accepts the held request |
| irq_valid | output | 1 | Interrupt request pending |
| irq_vector | output | 5 | Vector number of the pending request |

## Verification
The bench targets the comparison timing. A design that compared after the increment would flag compare A one count early, and it would also miss the match at 0xFFFF. The bench drives the clear-on-A path at 0xFFFF. A design that still reported the wrap there would raise vector 18 where 16 is due. The bench also fires all three events together to expose a wrong priority order. It races a flag clear against a new event to catch a design where the clear wins. It checks that a held request keeps its vector when a later event arrives, and that an acknowledge in the same cycle as a new event does not lose that event.

// File: rtl/frt_dual_cmp.sv
module frt_dual_cmp #(
  parameter int CW    = 16,
  parameter int AW    = 3,
  parameter int VW    = 5,
  parameter int VEC_A = 16,
  parameter int VEC_B = 17,
  parameter int VEC_O = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_we,
  input  logic [CW-1:0] bus_wdata,
  output logic [CW-1:0] bus_rdata,
  input  logic          irq_ack,
  output logic          irq_valid,
  output logic [VW-1:0] irq_vector
);
  localparam logic [AW-1:0] A_CNT = AW'(0);
  localparam logic [AW-1:0] A_CMA = AW'(1);
  localparam logic [AW-1:0] A_CMB = AW'(2);
  localparam logic [AW-1:0] A_STS = AW'(3);
  localparam logic [AW-1:0] A_ENA = AW'(4);
  localparam logic [CW-1:0] ALL1  = {CW{1'b1}};

  logic [CW-1:0] cnt, cmp_a, cmp_b;
  logic [2:0]    flags, en;
  logic          clr_on_a;

  logic wr_cnt, wr_sts, run;
  logic hit_a, hit_b, hit_o, clr_now;
  logic [2:0] evt, req;
  logic [2:0] flags_nx;
  logic [VW-1:0] vec_nx;
  logic wdata_unused;

  assign wdata_unused = ^bus_wdata[CW-1:4];

  assign wr_cnt  = bus_we && bus_addr == A_CNT;
  assign wr_sts  = bus_we && bus_addr == A_STS;
  assign run     = tick && !wr_cnt;
  assign hit_a   = run && cnt == cmp_a;
  assign hit_b   = run && cnt == cmp_b;
  assign clr_now = hit_a && clr_on_a;
  assign hit_o   = run && !clr_now && cnt == ALL1;
  assign evt     = {hit_o, hit_b, hit_a};
  assign req     = evt & en;

  always_comb begin
    flags_nx = wr_sts ? (flags & bus_wdata[2:0]) : flags;
    flags_nx = flags_nx | evt;
  end

  always_comb begin
    vec_nx = VW'(VEC_A);
    if (req[2])      vec_nx = VW'(VEC_O);
    else if (req[1]) vec_nx = VW'(VEC_B);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      cmp_a    <= ALL1;
      cmp_b    <= ALL1;
      flags    <= '0;
      clr_on_a <= 1'b0;
      en       <= '0;
    end else begin
      if (wr_cnt)       cnt <= bus_wdata;
      else if (clr_now) cnt <= '0;
      else if (run)     cnt <= cnt + 1'b1;
      if (bus_we && bus_addr == A_CMA) cmp_a <= bus_wdata;
      if (bus_we && bus_addr == A_CMB) cmp_b <= bus_wdata;
      if (bus_we && bus_addr == A_ENA) en    <= bus_wdata[2:0];
      if (wr_sts) clr_on_a <= bus_wdata[3];
      flags <= flags_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_valid  <= 1'b0;
      irq_vector <= '0;
    end else if (!irq_valid || irq_ack) begin
      irq_valid <= |req;
      if (|req) irq_vector <= vec_nx;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CNT:   bus_rdata = cnt;
      A_CMA:   bus_rdata = cmp_a;
      A_CMB:   bus_rdata = cmp_b;
      A_STS:   bus_rdata = CW'({clr_on_a, flags});
      A_ENA:   bus_rdata = CW'(en);
      default: bus_rdata = '0;
    endcase
  end

  a_r1_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_cnt) |=> $stable(cnt));

  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == cmp_a && clr_on_a) |=> (cnt == '0 && flags[0]));

  a_r4_b_no_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == cmp_b && cnt != cmp_a) |=> cnt == CW'($past(cnt) + 1'b1));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && cnt == ALL1 && !(clr_on_a && cmp_a == ALL1)) |=> flags[2]);

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flags[0] && !wr_sts) |=> flags[0]);

  a_r9_held: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_valid && !irq_ack) |=> (irq_valid && $stable(irq_vector)));

  a_r6_vec_range: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (irq_vector == VW'(VEC_A) || irq_vector == VW'(VEC_B) ||
                   irq_vector == VW'(VEC_O)));
endmodule

// File: tb/frt_dual_cmp_tb_top.sv
`timescale 1ns/1ps
module frt_dual_cmp_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0;
  logic [2:0] bus_addr = '0;
  logic bus_we = 1'b0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic irq_ack = 1'b0;
  logic irq_valid;
  logic [4:0] irq_vector;

  int n_chk = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  frt_dual_cmp dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_ack(irq_ack), .irq_valid(irq_valid), .irq_vector(irq_vector)
  );

  typedef struct packed {
    logic [15:0] start;
    logic [15:0] ca;
    logic [15:0] cb;
    logic        clr;
    logic [2:0]  en;
    logic [15:0] e_cnt;
    logic [2:0]  e_flg;
    logic        e_v;
    logic [4:0]  e_vec;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t TBL [NV] = '{
    '{16'd5,     16'd5,     16'd9,     1'b0, 3'b111, 16'd6,  3'b001, 1'b1, 5'd16},
    '{16'd5,     16'd5,     16'd9,     1'b1, 3'b000, 16'd0,  3'b001, 1'b0, 5'd0},
    '{16'd9,     16'd5,     16'd9,     1'b1, 3'b010, 16'd10, 3'b010, 1'b1, 5'd17},
    '{16'hFFFF,  16'd1,     16'd2,     1'b0, 3'b100, 16'd0,  3'b100, 1'b1, 5'd18},
    '{16'hFFFF,  16'hFFFF,  16'hFFFF,  1'b0, 3'b111, 16'd0,  3'b111, 1'b1, 5'd18},
    '{16'd7,     16'd7,     16'd7,     1'b0, 3'b011, 16'd8,  3'b011, 1'b1, 5'd17},
    '{16'hFFFF,  16'hFFFF,  16'd3,     1'b1, 3'b111, 16'd0,  3'b001, 1'b1, 5'd16},
    '{16'd20,    16'd21,    16'd22,    1'b0, 3'b111, 16'd21, 3'b000, 1'b0, 5'd0},
    '{16'd3,     16'd3,     16'd3,     1'b0, 3'b000, 16'd4,  3'b011, 1'b0, 5'd0}
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    bus_addr = a;
    #0.5;
    d = bus_rdata;
  endtask

  task automatic step_tick;
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  task automatic ack;
    @(negedge clk);
    irq_ack = 1'b1;
    @(negedge clk);
    irq_ack = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [15:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R11 reset state, R12 address map
    rd(3'd0, r); check("R11 counter", r, 16'h0000);
    rd(3'd1, r); check("R11 cmpA", r, 16'hFFFF);
    rd(3'd2, r); check("R11 cmpB", r, 16'hFFFF);
    rd(3'd3, r); check("R11 status", r, 16'h0000);
    rd(3'd4, r); check("R11 enable", r, 16'h0000);
    rd(3'd6, r); check("R12 unused address", r, 16'h0000);
    check("R11 irq_valid", {15'd0, irq_valid}, 16'd0);

    // R1 hold and count
    wr(3'd0, 16'd40);
    repeat (3) @(negedge clk);
    rd(3'd0, r); check("R1 hold without tick", r, 16'd40);
    step_tick(); step_tick(); step_tick();
    rd(3'd0, r); check("R1 three ticks", r, 16'd43);

    // table walk
    for (int i = 0; i < NV; i++) begin
      ack();
      wr(3'd3, {12'd0, TBL[i].clr, 3'b000});
      wr(3'd4, {13'd0, TBL[i].en});
      wr(3'd0, TBL[i].start);
      wr(3'd1, TBL[i].ca);
      wr(3'd2, TBL[i].cb);
      step_tick();
      rd(3'd0, r); check($sformatf("R2/R3/R4/R5 vec%0d counter", i), r, TBL[i].e_cnt);
      rd(3'd3, r); check($sformatf("R2/R3/R4/R5/R6 vec%0d flags", i), {13'd0, r[2:0]}, {13'd0, TBL[i].e_flg});
      check($sformatf("R6/R7 vec%0d request", i), {10'd0, irq_valid, irq_vector & {5{irq_valid}}},
            {10'd0, TBL[i].e_v, TBL[i].e_vec});
    end

    // R8 write 1 keeps, write 0 clears
    ack();
    wr(3'd3, 16'd0); wr(3'd4, 16'd0);
    wr(3'd1, 16'd50); wr(3'd0, 16'd50);
    step_tick();
    wr(3'd3, 16'h0007);
    rd(3'd3, r); check("R8 write one keeps flag", {15'd0, r[0]}, 16'd1);
    wr(3'd3, 16'h0006);
    rd(3'd3, r); check("R8 write zero clears flag", {15'd0, r[0]}, 16'd0);
    // R8 set wins over clear
    wr(3'd0, 16'd50);
    @(negedge clk);
    tick = 1'b1; bus_we = 1'b1; bus_addr = 3'd3; bus_wdata = 16'd0;
    @(negedge clk);
    tick = 1'b0; bus_we = 1'b0;
    rd(3'd3, r); check("R8 event beats clear", {15'd0, r[0]}, 16'd1);

    // R9 held request
    wr(3'd3, 16'd0);
    wr(3'd4, 16'h0003);
    wr(3'd1, 16'd5); wr(3'd2, 16'd6); wr(3'd0, 16'd5);
    step_tick();
    check("R9 first request", {10'd0, irq_valid, irq_vector}, {10'd0, 1'b1, 5'd16});
    step_tick();
    check("R9 held vector after new event", {10'd0, irq_valid, irq_vector}, {10'd0, 1'b1, 5'd16});
    rd(3'd3, r); check("R9 flag still recorded", {14'd0, r[1:0]}, 16'd3);
    ack();
    check("R9 ack drops request", {15'd0, irq_valid}, 16'd0);
    wr(3'd0, 16'd5);
    step_tick();
    @(negedge clk);
    tick = 1'b1; irq_ack = 1'b1;
    @(negedge clk);
    tick = 1'b0; irq_ack = 1'b0;
    check("R9 ack with new event", {10'd0, irq_valid, irq_vector}, {10'd0, 1'b1, 5'd17});

    // R10 counter write beats tick
    ack();
    wr(3'd3, 16'd0); wr(3'd4, 16'h0001);
    wr(3'd1, 16'd100); wr(3'd0, 16'd100);
    @(negedge clk);
    tick = 1'b1; bus_we = 1'b1; bus_addr = 3'd0; bus_wdata = 16'd500;
    @(negedge clk);
    tick = 1'b0; bus_we = 1'b0;
    rd(3'd0, r); check("R10 written value", r, 16'd500);
    rd(3'd3, r); check("R10 no compare flag", {13'd0, r[2:0]}, 16'd0);
    check("R10 no request", {15'd0, irq_valid}, 16'd0);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule